// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Clock Divider

This block divides its input clock by a programmable 15-bit integer N and emits one single-cycle pulse per N input cycles. Internally it is built as a pulse-swallow divider: a prescaler that divides by 16 or 17 drives a main counter (M = N[14:4]) and a swallow counter (A = N[3:0]). For the first A prescaler cycles of each output period the prescaler divides by 17, and for the rest it divides by 16, so one output period lasts 16·M + A = N input cycles.

The ratio is loaded as two bytes through a simple byte-write port: an upper byte carrying N[14:8] and a lower byte carrying N[7:0]. The bytes are held in a shadow stage. A new ratio is committed only once both halves have been written, in either order, even when only one of them changed. The committed value is clamped to the lowest ratio the structure supports (240). An error flag reports whether it was clamped. The value is then applied at the next output-period boundary, so no period ever has a mixed length.

Top module: `pulse_swallow_div`

## Requirements
- R1: A write with `wr_sel`=0 loads the upper byte, and its bits 6:0 become N[14:8] (bit 7 is ignored). A write with `wr_sel`=1 loads the lower byte, which becomes N[7:0].
- R2: For a committed N from 240 to 32767, the interval between consecutive `div_pulse` rising edges is exactly N clock cycles, and each pulse is high for one cycle.
- R3: A ratio is committed only by the write that completes a pair (one upper and one lower byte, in either order). A lone byte write leaves the output period unchanged.
- R4: The write-tracking state clears on commit. After a commit, a single further byte write does not commit, and it pairs with the next write of the other half.
- R5: The output period in progress when a commit happens keeps its old length. The new ratio applies from the following period.
- R6: A committed N below 240 is replaced by 240, and `range_err` goes to 1. A committed N of 240 or more sets `range_err` to 0. The flag updates on the clock edge that commits.
- R7: During and after reset, the held ratio is 0 and `range_err` is 0. `div_pulse` is low during reset. The output period after reset is 240 cycles, because the reset ratio is clamped.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_sel | input | 1 | 0 = upper ratio byte, 1 = lower ratio byte |
| wr_data | input | 8 | Byte being written |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| range_err | output | 1 | Last committed ratio was below 240 and was clamped |

## Verification
If the swallow counter or the prescaler modulus is wrong, every output period becomes too long or too short by a whole number of cycles. The bench sees this at the first full period measured after a commit. A fault in commit tracking shows up as a period length that changes after a single byte write, or one that fails to change after a completed pair, within two periods. A fault in where the ratio is applied shows up as a mixed-length period right at the boundary that follows a commit. The clamp fault shows up at once in `range_err`, and within one period as a period that is not 240.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned RATIO_W  = 15;
  localparam int unsigned RATIO_LO = 240;
  localparam int unsigned PRESC_W  = 4;
endpackage

// File: rtl/psd_shadow.sv
module psd_shadow #(
  parameter int unsigned RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [7:0]         wr_data,
  output logic               commit_vld,
  output logic [RATIO_W-1:0] commit_n
);
  localparam int unsigned HI_W = RATIO_W - 8;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [7:0]      lo_q, lo_d;
  logic            hi_seen_q, hi_seen_d;
  logic            lo_seen_q, lo_seen_d;
  logic            hi_wr, lo_wr;

  assign hi_wr = wr_en && !wr_sel;
  assign lo_wr = wr_en &&  wr_sel;

  always_comb begin
    hi_d       = hi_q;
    lo_d       = lo_q;
    hi_seen_d  = hi_seen_q;
    lo_seen_d  = lo_seen_q;
    commit_vld = 1'b0;
    if (hi_wr) begin
      hi_d      = wr_data[HI_W-1:0];
      hi_seen_d = 1'b1;
    end
    if (lo_wr) begin
      lo_d      = wr_data;
      lo_seen_d = 1'b1;
    end
    if (hi_seen_d && lo_seen_d) begin
      commit_vld = 1'b1;
      hi_seen_d  = 1'b0;
      lo_seen_d  = 1'b0;
    end
  end

  assign commit_n = {hi_d, lo_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      hi_seen_q <= 1'b0;
      lo_seen_q <= 1'b0;
    end else begin
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      hi_seen_q <= hi_seen_d;
      lo_seen_q <= lo_seen_d;
    end
  end
endmodule

// File: rtl/psd_ratio.sv
module psd_ratio #(
  parameter int unsigned RATIO_W  = 15,
  parameter int unsigned RATIO_LO = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_vld,
  input  logic [RATIO_W-1:0] commit_n,
  input  logic               period_end,
  output logic [RATIO_W-1:0] load_n,
  output logic               range_err
);
  localparam logic [RATIO_W-1:0] LO_N = RATIO_W'(RATIO_LO);

  logic [RATIO_W-1:0] act_q, act_d;
  logic [RATIO_W-1:0] pend_q, pend_d;
  logic               pend_vld_q, pend_vld_d;
  logic               err_q, err_d;
  logic               too_low;

  assign too_low = commit_n < LO_N;
  assign load_n  = pend_vld_q ? pend_q : act_q;

  always_comb begin
    act_d      = act_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    err_d      = err_q;
    if (period_end) begin
      act_d      = load_n;
      pend_vld_d = 1'b0;
    end
    if (commit_vld) begin
      pend_d     = too_low ? LO_N : commit_n;
      pend_vld_d = 1'b1;
      err_d      = too_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= LO_N;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      act_q      <= act_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      err_q      <= err_d;
    end
  end

  assign range_err = err_q;
endmodule

// File: rtl/psd_core.sv
module psd_core #(
  parameter int unsigned RATIO_W  = 15,
  parameter int unsigned PRESC_W  = 4,
  parameter int unsigned RATIO_LO = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] load_n,
  output logic               period_end,
  output logic               div_pulse
);
  localparam int unsigned M_W   = RATIO_W - PRESC_W;
  localparam int unsigned C_W   = PRESC_W + 1;
  localparam int unsigned PS    = 1 << PRESC_W;
  localparam logic [C_W-1:0] CNT_LONG  = C_W'(PS);
  localparam logic [C_W-1:0] CNT_SHORT = C_W'(PS - 1);
  localparam logic [RATIO_W-1:0] LO_N  = RATIO_W'(RATIO_LO);
  localparam logic [M_W-1:0]     RST_M = LO_N[RATIO_W-1:PRESC_W];
  localparam logic [PRESC_W-1:0] RST_A = LO_N[PRESC_W-1:0];

  logic [C_W-1:0]     pre_q, pre_d;
  logic [M_W-1:0]     m_q, m_d;
  logic [PRESC_W-1:0] a_q, a_d;
  logic               pulse_q;
  logic               pre_tc;
  logic [M_W-1:0]     ld_m;
  logic [PRESC_W-1:0] ld_a;

  assign ld_m       = load_n[RATIO_W-1:PRESC_W];
  assign ld_a       = load_n[PRESC_W-1:0];
  assign pre_tc     = (pre_q == '0);
  assign period_end = pre_tc && (m_q == M_W'(1));

  always_comb begin
    pre_d = pre_q;
    m_d   = m_q;
    a_d   = a_q;
    if (!pre_tc) begin
      pre_d = pre_q - C_W'(1);
    end else if (period_end) begin
      m_d   = ld_m;
      a_d   = ld_a;
      pre_d = (ld_a != '0) ? CNT_LONG : CNT_SHORT;
    end else begin
      m_d   = m_q - M_W'(1);
      a_d   = (a_q != '0) ? a_q - PRESC_W'(1) : a_q;
      pre_d = (a_d != '0) ? CNT_LONG : CNT_SHORT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= (RST_A != '0) ? CNT_LONG : CNT_SHORT;
      m_q     <= RST_M;
      a_q     <= RST_A;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      m_q     <= m_d;
      a_q     <= a_d;
      pulse_q <= period_end;
    end
  end

  assign div_pulse = pulse_q;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned N_W   = RATIO_W,
  parameter int unsigned N_MIN = RATIO_LO,
  parameter int unsigned P_W   = PRESC_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       div_pulse,
  output logic       range_err
);
  logic           commit_vld;
  logic [N_W-1:0] commit_n;
  logic [N_W-1:0] load_n;
  logic           period_end;

  psd_shadow #(.RATIO_W(N_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .commit_vld(commit_vld), .commit_n(commit_n)
  );

  psd_ratio #(.RATIO_W(N_W), .RATIO_LO(N_MIN)) u_ratio (
    .clk(clk), .rst_n(rst_n), .commit_vld(commit_vld), .commit_n(commit_n),
    .period_end(period_end), .load_n(load_n), .range_err(range_err)
  );

  psd_core #(.RATIO_W(N_W), .PRESC_W(P_W), .RATIO_LO(N_MIN)) u_core (
    .clk(clk), .rst_n(rst_n), .load_n(load_n),
    .period_end(period_end), .div_pulse(div_pulse)
  );
endmodule

// File: rtl/psd_chk.sv
module psd_chk #(
  parameter int unsigned N_W   = 15,
  parameter int unsigned N_MIN = 240
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           div_pulse,
  input logic           range_err,
  input logic           commit_vld,
  input logic [N_W-1:0] commit_n,
  input logic [N_W-1:0] load_n,
  input logic           period_end
);
  logic [N_W:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (div_pulse) gap_q <= (N_W+1)'(1);
    else if (gap_q != '1) gap_q <= gap_q + (N_W+1)'(1);
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R2
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> gap_q >= (N_W+1)'(N_MIN - 1));

  // R3
  commit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> wr_en);

  // R6
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |=> (range_err == ($past(commit_n) < N_W'(N_MIN))));

  // R5
  load_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(commit_vld) && !$past(period_end)) |-> $stable(load_n));
endmodule

bind pulse_swallow_div psd_chk #(.N_W(N_W), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .div_pulse(div_pulse),
  .range_err(range_err), .commit_vld(commit_vld), .commit_n(commit_n),
  .load_n(load_n), .period_end(period_end)
);

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       div_pulse;
  logic       range_err;
  int         errs = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  pulse_swallow_div dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .div_pulse(div_pulse), .range_err(range_err)
  );

  function automatic int exp_period(int n);
    return (n < 240) ? 240 : n;
  endfunction

  function automatic bit exp_flag(int n);
    return n < 240;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 40000);
  endtask

  // Writes nwr bytes right after a pulse. The period in progress must keep
  // old_n, and the following period must be new_n.
  task automatic step(int nwr, bit s0, logic [7:0] d0, bit s1, logic [7:0] d1,
                      int old_n, int new_n, string tag);
    int rest, len;
    wait_pulse(rest);
    wr_byte(s0, d0);
    if (nwr > 1) wr_byte(s1, d1);
    wait_pulse(rest);
    chk(rest + nwr == old_n, {tag, " R5 period in progress"}, rest + nwr, old_n);
    wait_pulse(len);
    chk(len == new_n, {tag, " R2 new period"}, len, new_n);
  endtask

  task automatic set_ratio(int n, bit lo_first, int old_n, string tag);
    logic [7:0] hi, lo;
    hi = {1'b0, n[14:8]};
    lo = n[7:0];
    if (lo_first) step(2, 1'b1, lo, 1'b0, hi, old_n, exp_period(n), tag);
    else          step(2, 1'b0, hi, 1'b1, lo, old_n, exp_period(n), tag);
    chk(range_err == exp_flag(n), {tag, " R6 flag"}, range_err, exp_flag(n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cur, len, n, seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(div_pulse == 1'b0, "R7 pulse low in reset", div_pulse, 0);
    chk(range_err == 1'b0, "R7 flag low in reset", range_err, 0);
    rst_n = 1'b1;
    wait_pulse(len);
    wait_pulse(len);
    chk(len == 240, "R7 period after reset", len, 240);
    chk(range_err == 1'b0, "R7 flag after reset", range_err, 0);
    cur = 240;

    // R1 R3 upper then lower, then lower then upper
    set_ratio(1000, 1'b0, cur, "R1 hi-lo"); cur = 1000;
    set_ratio(777, 1'b1, cur, "R3 lo-hi"); cur = 777;
    set_ratio(500, 1'b0, cur, "R1 500"); cur = 500;

    // R3 a lone upper byte leaves the period unchanged
    step(1, 1'b0, 8'h03, 1'b0, 8'h00, cur, cur, "R3 lone upper");
    wait_pulse(len);
    chk(len == cur, "R3 still unchanged", len, cur);
    // the lower byte completes the pair: N = 0x320 = 800
    step(1, 1'b1, 8'h20, 1'b0, 8'h00, cur, 800, "R3 pair completes");
    cur = 800;
    // R4 flags cleared: a lone lower byte does not commit
    step(1, 1'b1, 8'h10, 1'b0, 8'h00, cur, cur, "R4 lone lower after commit");
    // R4 the upper byte then pairs with it: N = 0x110 = 272
    step(1, 1'b0, 8'h01, 1'b0, 8'h00, cur, 272, "R4 pairs later");
    cur = 272;

    // R6 clamp and flag
    set_ratio(100, 1'b0, cur, "R6 100"); cur = 240;
    set_ratio(239, 1'b1, cur, "R6 239"); cur = 240;
    set_ratio(0, 1'b0, cur, "R6 zero"); cur = 240;
    set_ratio(240, 1'b0, cur, "R6 240"); cur = 240;
    set_ratio(241, 1'b1, cur, "R2 241"); cur = 241;

    // random ratios
    for (int i = 0; i < 8; i++) begin
      n = 240 + int'($urandom % 1800);
      set_ratio(n, ($urandom % 2) == 1, cur, "R2 random");
      cur = n;
    end

    // R1 bit 7 of upper byte ignored, R2 largest ratio
    step(2, 1'b0, 8'hFF, 1'b1, 8'hFF, cur, 32767, "R1 bit7 max");
    chk(range_err == 1'b0, "R6 flag max", range_err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule